// File: doc/BRIEF.md
# Maskable Interrupt Generator

This block gathers event sources into one sticky status register and drives a single interrupt pin toward an external microcontroller. The sources are an ADC conversion-ready pulse, a real-time-clock alarm pulse, a set of supply-monitor level flags and a set of general-purpose input pins. Each input pin raises its event on a rising or a falling edge, chosen pin by pin. Each status bit is gated by its own bit in a mask register. The OR of the unmasked bits is registered and driven out at a programmable active level.

Software reaches the block through a plain register port with four words. The status word is write-one-to-clear. The other three words hold the mask, the output configuration and the edge selects. All register accesses complete in one cycle. Reads are combinational from the address.

Top module: `irq_gen_top`

## Requirements
- R1: After reset, status reads 0, mask reads 0x01 (only conversion-ready unmasked), config reads 0x02 (enable=1, active-low=0), edge-select reads 0 and irq_o is 0.
- R2: A one-cycle pulse on conv_rdy_i or rtc_alarm_i sampled at a clock edge sets status bit 0 or bit 1 at that edge. The bit then stays set until it is cleared.
- R3: Each supply_low_i bit passes through a two-flop synchroniser. While the synchronised level is high, it sets status bit 2+k. A clear while the level is still high is therefore overridden.
- R4: Each gpio_i bit passes through a two-flop synchroniser. Edge-select bit k chooses the edge for pin k: 0 means rising and 1 means falling. A matching edge sets status bit 2+N_SUPPLY+k, and the opposite edge sets nothing.
- R5: A write to address 0 clears each status bit whose write-data bit is 1. Bits whose write-data bit is 0 are unchanged.
- R6: When an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R7: irq_o is registered. Its active level is driven exactly when the OR over (status AND mask) is 1, so a masked source never asserts it.
- R8: Config bit 0 (address 2) selects the active level: 0 means active-high and 1 means active-low.
- R9: When config bit 1 (address 2, enable) is 0, irq_o is held at its inactive level whatever the status.
- R10: Writing the mask (address 1) leaves the status unchanged. Unmasking a bit that is already set drives irq_o active on the clock after the mask write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_rdy_i | input | 1 | Conversion-ready pulse, synchronous to clk |
| rtc_alarm_i | input | 1 | RTC alarm pulse, synchronous to clk |
| supply_low_i | input | N_SUPPLY | Supply-monitor level flags, asynchronous |
| gpio_i | input | N_GPIO | General-purpose input pins, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 status, 1 mask, 2 config, 3 edge-select |
| reg_wdata_i | input | NSRC | Register write data |
| reg_rdata_o | output | NSRC | Register read data for reg_addr_i |
| irq_o | output | 1 | Interrupt pin |

## Verification
The assertions assume three things about the inputs. The conversion-ready and alarm pulses are synchronous to clk. The supply and pin inputs hold each level long enough for the synchroniser to catch it. Register writes present a stable address and data through the write edge. The bench changes every input on the falling clock edge. It holds pin and supply levels for four or more cycles, and it keeps all events quiet during the mask-write checks. This quiet period keeps the status-stability property meaningful.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_MASK   = 2'd1,
    ADDR_CFG    = 2'd2,
    ADDR_EDGE   = 2'd3
  } reg_addr_e;

  localparam int CFG_POL_BIT = 0;
  localparam int CFG_EN_BIT  = 1;
  localparam int SRC_CONV    = 0;
  localparam int SRC_RTC     = 1;
  localparam int SRC_SUP_LSB = 2;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] fall_sel_i,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_i;
  end

  for (genvar k = 0; k < W; k++) begin : g_pin
    assign edge_o[k] = fall_sel_i[k] ? (prev_q[k] & ~sync_i[k])
                                     : (~prev_q[k] & sync_i[k]);
  end

  // R4
  edge_follows_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o != '0) |=> ((($past(edge_o) & ~($past(sync_i) ^ $past(prev_q)))) == '0));
endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_i) | set_i;
  end

  assign status_o = status_q;

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((($past(status_q) & ~$past(clr_i)) & ~status_q)) == '0));

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irq_out.sv
module irq_out #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  input  logic         pol_low_i,
  input  logic         en_i,
  output logic         irq_o
);
  logic pending;
  logic irq_q;

  assign pending = |(status_i & mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    irq_q <= 1'b0;
    else if (en_i) irq_q <= pending ^ pol_low_i;
    else           irq_q <= pol_low_i;
  end

  assign irq_o = irq_q;

  // R9
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (irq_o == $past(pol_low_i)));

  // R7
  pending_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && pending) |=> (irq_o != $past(pol_low_i)));
endmodule

// File: rtl/irq_gen_top.sv
module irq_gen_top #(
  parameter int N_GPIO   = 4,
  parameter int N_SUPPLY = 2,
  localparam int NSRC    = 2 + N_SUPPLY + N_GPIO
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                conv_rdy_i,
  input  logic                rtc_alarm_i,
  input  logic [N_SUPPLY-1:0] supply_low_i,
  input  logic [N_GPIO-1:0]   gpio_i,
  input  logic                reg_wr_i,
  input  logic [1:0]          reg_addr_i,
  input  logic [NSRC-1:0]     reg_wdata_i,
  output logic [NSRC-1:0]     reg_rdata_o,
  output logic                irq_o
);
  import irq_pkg::*;

  localparam logic [NSRC-1:0] MASK_RST = NSRC'(1) << SRC_CONV;

  logic [N_SUPPLY-1:0] sup_sync;
  logic [N_GPIO-1:0]   pin_sync;
  logic [N_GPIO-1:0]   pin_edge;
  logic [N_GPIO-1:0]   fall_sel_q;
  logic [NSRC-1:0]     mask_q;
  logic [NSRC-1:0]     status;
  logic [NSRC-1:0]     set_vec;
  logic [NSRC-1:0]     clr_vec;
  logic                pol_low_q;
  logic                en_q;
  reg_addr_e           addr;

  assign addr = reg_addr_e'(reg_addr_i);

  irq_sync #(.W(N_SUPPLY), .STAGES(2)) i_sup_sync (
    .clk(clk), .rst_n(rst_n), .async_i(supply_low_i), .sync_o(sup_sync));

  irq_sync #(.W(N_GPIO), .STAGES(2)) i_pin_sync (
    .clk(clk), .rst_n(rst_n), .async_i(gpio_i), .sync_o(pin_sync));

  irq_edge_det #(.W(N_GPIO)) i_edge (
    .clk(clk), .rst_n(rst_n), .sync_i(pin_sync),
    .fall_sel_i(fall_sel_q), .edge_o(pin_edge));

  assign set_vec = {pin_edge, sup_sync, rtc_alarm_i, conv_rdy_i};
  assign clr_vec = (reg_wr_i && addr == ADDR_STATUS) ? reg_wdata_i : '0;

  irq_status #(.W(NSRC)) i_status (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec),
    .status_o(status));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= MASK_RST;
      pol_low_q  <= 1'b0;
      en_q       <= 1'b1;
      fall_sel_q <= '0;
    end else if (reg_wr_i) begin
      case (addr)
        ADDR_MASK: mask_q     <= reg_wdata_i;
        ADDR_CFG: begin
          pol_low_q <= reg_wdata_i[CFG_POL_BIT];
          en_q      <= reg_wdata_i[CFG_EN_BIT];
        end
        ADDR_EDGE: fall_sel_q <= reg_wdata_i[N_GPIO-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (addr)
      ADDR_STATUS: reg_rdata_o = status;
      ADDR_MASK:   reg_rdata_o = mask_q;
      ADDR_CFG: begin
        reg_rdata_o[CFG_POL_BIT] = pol_low_q;
        reg_rdata_o[CFG_EN_BIT]  = en_q;
      end
      ADDR_EDGE:   reg_rdata_o[N_GPIO-1:0] = fall_sel_q;
      default: ;
    endcase
  end

  irq_out #(.W(NSRC)) i_out (
    .clk(clk), .rst_n(rst_n), .status_i(status), .mask_i(mask_q),
    .pol_low_i(pol_low_q), .en_i(en_q), .irq_o(irq_o));

  // R10
  mask_keeps_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && addr == ADDR_MASK && set_vec == '0) |=> (status == $past(status)));

  // R8
  pol_follows_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && (status & mask_q) == '0) |=> (irq_o == $past(pol_low_q)));
endmodule

// File: tb/test_irq_gen_top.sv
module test_irq_gen_top;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 4;
  localparam int NS = 2;
  localparam int NSRC = 2 + NS + NG;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_rdy = 1'b0, rtc_alarm = 1'b0;
  logic [NS-1:0] supply = '0;
  logic [NG-1:0] gpio = '0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [NSRC-1:0] reg_wdata = '0;
  logic [NSRC-1:0] reg_rdata;
  logic irq;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_gen_top #(.N_GPIO(NG), .N_SUPPLY(NS)) i_irq_gen_top (
    .clk(clk), .rst_n(rst_n), .conv_rdy_i(conv_rdy), .rtc_alarm_i(rtc_alarm),
    .supply_low_i(supply), .gpio_i(gpio), .reg_wr_i(reg_wr),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq));

  // fields: mask[12:5] cfg{en,pol}[4:3] events{rtc,conv}[2:1] irq[0]
  localparam logic [12:0] VEC [0:6] = '{
    {8'h01, 2'b10, 2'b01, 1'b1},
    {8'h01, 2'b10, 2'b10, 1'b0},
    {8'h02, 2'b11, 2'b10, 1'b0},
    {8'h02, 2'b11, 2'b01, 1'b1},
    {8'hFF, 2'b00, 2'b11, 1'b0},
    {8'hFF, 2'b01, 2'b11, 1'b1},
    {8'h00, 2'b10, 2'b11, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [NSRC-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [NSRC-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [NSRC-1:0] d;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    // R1 reset state
    rd(2'd0, d); check("R1 status", d, 0);
    rd(2'd1, d); check("R1 mask", d, 8'h01);
    rd(2'd2, d); check("R1 config", d, 8'h02);
    rd(2'd3, d); check("R1 edge", d, 0);
    check("R1 irq", irq, 0);

    // table: R2 R7 R8 R9
    for (int i = 0; i < 7; i++) begin
      wr(2'd1, VEC[i][12:5]);
      wr(2'd2, {6'b0, VEC[i][4:3]});
      wr(2'd0, '1);
      @(negedge clk);
      conv_rdy = VEC[i][1]; rtc_alarm = VEC[i][2];
      @(negedge clk);
      conv_rdy = 1'b0; rtc_alarm = 1'b0;
      @(negedge clk);
      check("R7/R8/R9 irq vector", irq, VEC[i][0]);
      rd(2'd0, d); check("R2 status vector", d, {6'b0, VEC[i][2:1]});
    end

    wr(2'd2, 8'h02);
    wr(2'd1, 8'h00);
    wr(2'd0, '1);
    // R3 supply level, re-set while high
    @(negedge clk) supply = 2'b10;
    wait_cyc(4);
    rd(2'd0, d); check("R3 supply set", d, 8'h08);
    wr(2'd0, 8'h08);
    wait_cyc(1);
    rd(2'd0, d); check("R3 clear overridden while high", d, 8'h08);
    @(negedge clk) supply = 2'b00;
    wait_cyc(4);
    wr(2'd0, 8'h08);
    rd(2'd0, d); check("R3 cleared after drop", d, 8'h00);

    // R4 rising default, falling ignored
    @(negedge clk) gpio = 4'b0001;
    wait_cyc(4);
    rd(2'd0, d); check("R4 rising edge", d, 8'h10);
    wr(2'd0, '1);
    @(negedge clk) gpio = 4'b0000;
    wait_cyc(4);
    rd(2'd0, d); check("R4 falling ignored", d, 8'h00);
    wr(2'd3, 8'h04);
    rd(2'd3, d); check("R4 edge select readback", d, 8'h04);
    @(negedge clk) gpio = 4'b0100;
    wait_cyc(4);
    rd(2'd0, d); check("R4 rising ignored on falling pin", d, 8'h00);
    @(negedge clk) gpio = 4'b0000;
    wait_cyc(4);
    rd(2'd0, d); check("R4 falling edge", d, 8'h40);

    // R5 write-one-to-clear
    @(negedge clk) begin conv_rdy = 1'b1; rtc_alarm = 1'b1; end
    @(negedge clk) begin conv_rdy = 1'b0; rtc_alarm = 1'b0; end
    wr(2'd0, 8'h00);
    rd(2'd0, d); check("R5 zero write no effect", d, 8'h43);
    wr(2'd0, 8'h41);
    rd(2'd0, d); check("R5 selective clear", d, 8'h02);
    wr(2'd0, '1);

    // R6 event beats clear
    @(negedge clk);
    conv_rdy = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h01;
    @(negedge clk);
    conv_rdy = 1'b0; reg_wr = 1'b0;
    rd(2'd0, d); check("R6 set wins", d, 8'h01);
    wr(2'd0, 8'h01);
    rd(2'd0, d); check("R6 later clear", d, 8'h00);

    // R10 mask write keeps status, unmask asserts next clock
    wr(2'd1, 8'h00);
    @(negedge clk) rtc_alarm = 1'b1;
    @(negedge clk) rtc_alarm = 1'b0;
    @(negedge clk);
    check("R7 masked source idle", irq, 0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h02;
    @(negedge clk);
    reg_wr = 1'b0;
    #1 check("R10 irq before output edge", irq, 0);
    @(negedge clk);
    check("R10 irq after unmask", irq, 1);
    rd(2'd0, d); check("R10 status unchanged", d, 8'h02);
    wr(2'd1, 8'h00);
    rd(2'd0, d); check("R10 status after remask", d, 8'h02);
    @(negedge clk);
    check("R7 irq drops after remask", irq, 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule